// File: doc/BRIEF.md
# Wishbone Load/Store Lane Port

This block sits between a small processor datapath and a Wishbone bus and turns one load, store or instruction fetch into a bus transfer. The datapath supplies a request strobe, a write flag, an access size, an extension mode, an instruction-fetch flag, the latched data address, the program counter and the latched store data. The block drives the bus cycle, strobe, write enable, word address, byte-lane selects and lane-replicated write data. It returns read data that has been shifted down from the addressed lane and extended to 32 bits, together with a flag that marks the acknowledge cycle.

The bus strobe follows the request. Once an acknowledge has been seen, the strobe is withheld for exactly one cycle, even if the datapath keeps its request asserted. A sequencer can therefore hold the request in a wait state and never issue a second transfer by accident. After a data access completes, the cycle signal stays high until the next instruction fetch has been acknowledged. The data access and the fetch that follows it then form one block cycle on the bus.

Top module: `lsu_wb_port`

## Requirements
- R1: While reset is low, the port leaves the block-cycle hold and the acknowledge-gap state cleared. After reset, with no request pending, cycle, strobe, write enable and the valid flag are all low.
- R2: The strobe is high whenever the request input is high, except in the cycle that follows an acknowledge. The bus address is the selected source address with its two low bits cleared. The source is the data address for loads and stores and the program counter for fetches.
- R3: In the cycle after a strobed acknowledge, the strobe is low even if the request input is still high. In the cycle after that, the strobe follows the request again.
- R4: The valid flag is high exactly in a cycle in which the strobe and the acknowledge are both high, for a read and for a write.
- R5: Size code 1 (byte) selects the single lane numbered by address bits [1:0], with one select bit per lane and lane 0 holding bits 7:0. The write data carries store bits 7:0 in all four lanes.
- R6: Size code 2 (halfword) selects lanes 0 and 1 (select 0x3) when address bit 1 is 0, and lanes 2 and 3 (select 0xC) when it is 1. The write data carries store bits 15:0 in both halves.
- R7: Size codes 3 (word) and 0 (auto, on a load or store) select all lanes (0xF) and pass the store data through unchanged.
- R8: When the fetch flag is high, the size and write inputs are ignored. The transfer is a full-word read (select 0xF, write enable low) from the program counter, and the returned data is the whole bus word.
- R9: With extend code 0 (zero), a byte load returns the addressed lane in bits 7:0 with the upper bits zero. A halfword load returns the addressed half in bits 15:0 with the upper bits zero.
- R10: With extend code 1 (sign), byte and halfword loads copy the top bit of the extracted field into all upper bits. Word loads are returned unchanged.
- R11: After a data access (fetch flag low) is acknowledged, the cycle signal stays high, even with no request, until a fetch is acknowledged. After an acknowledged fetch, the cycle signal falls as soon as there is no request.
- R12: Write enable is high only while the strobe is high on a non-fetch request whose write flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start or continue a memory request |
| write_i | input | 1 | Request is a store |
| size_i | input | 2 | Access size: 0 auto, 1 byte, 2 halfword, 3 word |
| sext_i | input | 1 | Extension of loaded data: 0 zero, 1 sign |
| fetch_i | input | 1 | Request is an instruction fetch |
| addr_i | input | 32 | Latched data address |
| pc_i | input | 32 | Program counter, used as the fetch address |
| wdata_i | input | 32 | Latched store data |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 32 | Word-aligned bus address |
| wb_sel_o | output | 4 | Byte-lane selects |
| wb_dat_o | output | 32 | Lane-replicated write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| rdata_o | output | 32 | Extracted and extended read data |
| valid_o | output | 1 | Read data valid or write complete |

## Verification
The bench checks that the strobe drops for exactly one cycle after an acknowledge while the request is still held. A port without that gap would issue a second transfer, and one that never recovered would hang the sequencer in its wait loop. It checks that the cycle signal survives the idle gap between a store and the next fetch and is released after the fetch. A wrong hold would either break the block cycle or keep the bus locked. It compares lanes and extension at the high addresses (byte 3, upper halfword) with negative and positive fields, where a wrong shift or a missing sign copy shows up. It also confirms that a fetch overrides a byte size and a set write flag.

// File: rtl/lsu_wb_pkg.sv
// Shared types and widths of the load/store lane port.
package lsu_wb_pkg;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int LANE_W   = $clog2(LANES);

    // Access size code, as driven by the sequencer.
    typedef enum logic [1:0] {
        SZ_AUTO = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } size_e;
endpackage

// File: rtl/lsu_req_ctl.sv
// Bus handshake control: derives strobe and cycle from the request.
// An acknowledge gates the strobe off for one cycle. An acknowledged data
// access holds the cycle up until a fetch has been acknowledged.
// Assumes the acknowledge is only meaningful while the strobe is high.
module lsu_req_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fetch_i,
    input  logic ack_i,
    output logic stb_o,
    output logic cyc_o
);
    logic ack_gap_q;
    logic blk_hold_q;
    logic done;

    // Strobe follows the request except in the cycle right after an ack.
    always_comb stb_o = req_i && !ack_gap_q;

    // A transfer finishes when the strobed request is acknowledged.
    always_comb done = stb_o && ack_i;

    // Cycle is raised by the strobe or by a pending block-cycle hold.
    always_comb cyc_o = stb_o || blk_hold_q;

    // Remember an acknowledge for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_gap_q <= 1'b0;
        else        ack_gap_q <= done;
    end

    // Set the hold after a data access, release it after a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    blk_hold_q <= 1'b0;
        else if (done) blk_hold_q <= !fetch_i;
    end
endmodule

// File: rtl/lsu_lane_sel.sv
// Write-side lane logic: byte selects from the size and the low address
// bits, and store data copied into every lane of the access width.
// Assumes that misaligned halfwords use address bit 1 only.
module lsu_lane_sel
    import lsu_wb_pkg::*;
(
    input  size_e              size_i,
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [LANES-1:0]   sel_o,
    output logic [DATA_W-1:0]  wdata_o
);
    // One select bit per lane, built from the lane index.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [LANE_W-1:0] KIDX = LANE_W'(k);
        always_comb begin
            unique case (size_i)
                SZ_BYTE: sel_o[k] = (lane_i == KIDX);
                SZ_HALF: sel_o[k] = (lane_i[LANE_W-1] == KIDX[LANE_W-1]);
                default: sel_o[k] = 1'b1;
            endcase
        end
    end

    // Replicate the low byte or halfword across the bus width.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: wdata_o = {LANES{wdata_i[7:0]}};
            SZ_HALF: wdata_o = {(LANES/2){wdata_i[15:0]}};
            default: wdata_o = wdata_i;
        endcase
    end
endmodule

// File: rtl/lsu_read_align.sv
// Read-side lane logic: shifts the addressed lane down to bit 0 and
// extends it to the full width with zeros or copies of its top bit.
// Assumes a word access always starts at lane 0.
module lsu_read_align
    import lsu_wb_pkg::*;
(
    input  size_e              size_i,
    input  logic [LANE_W-1:0]  lane_i,
    input  logic               sext_i,
    input  logic [DATA_W-1:0]  dat_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [LANE_W-1:0] base;
    logic [DATA_W-1:0] shifted;

    // Lowest lane of the access.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: base = lane_i;
            SZ_HALF: base = {lane_i[LANE_W-1], {(LANE_W-1){1'b0}}};
            default: base = '0;
        endcase
    end

    // Bring the addressed lane down to bit 0.
    always_comb shifted = dat_i >> {base, 3'b000};

    // Extend according to size and mode.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: rdata_o = {{(DATA_W-8){sext_i && shifted[7]}}, shifted[7:0]};
            SZ_HALF: rdata_o = {{(DATA_W-16){sext_i && shifted[15]}}, shifted[15:0]};
            default: rdata_o = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_wb_port.sv
// Load/store lane port to a Wishbone bus. Selects the address source,
// resolves the effective size, and combines the handshake, write-lane and
// read-lane submodules. Assumes a single master with no arbitration and
// no misalignment checking.
module lsu_wb_port
    import lsu_wb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              write_i,
    input  logic [1:0]        size_i,
    input  logic              sext_i,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [LANES-1:0]  wb_sel_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              valid_o
);
    logic [ADDR_W-1:0] src_adr;
    size_e             eff_size;
    logic              stb;

    // A fetch uses the PC; loads and stores use the latched address.
    always_comb src_adr = fetch_i ? pc_i : addr_i;

    // Fetch and auto both resolve to a full word.
    always_comb begin
        if (fetch_i || size_e'(size_i) == SZ_AUTO) eff_size = SZ_WORD;
        else                                        eff_size = size_e'(size_i);
    end

    // Handshake and block-cycle control.
    lsu_req_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .fetch_i (fetch_i),
        .ack_i   (wb_ack_i),
        .stb_o   (stb),
        .cyc_o   (wb_cyc_o)
    );

    // Write-side selects and replicated data.
    lsu_lane_sel u_wr (
        .size_i  (eff_size),
        .lane_i  (src_adr[LANE_W-1:0]),
        .wdata_i (wdata_i),
        .sel_o   (wb_sel_o),
        .wdata_o (wb_dat_o)
    );

    // Read-side extraction and extension.
    lsu_read_align u_rd (
        .size_i  (eff_size),
        .lane_i  (src_adr[LANE_W-1:0]),
        .sext_i  (sext_i),
        .dat_i   (wb_dat_i),
        .rdata_o (rdata_o)
    );

    // Bus-facing strobe, write enable, address and completion flag.
    always_comb begin
        wb_stb_o = stb;
        wb_we_o  = stb && write_i && !fetch_i;
        wb_adr_o = {src_adr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        valid_o  = stb && wb_ack_i;
    end
endmodule

// File: rtl/lsu_wb_port_chk.sv
// Protocol checker for the load/store lane port, attached by bind.
module lsu_wb_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       write_i,
    input logic [1:0] size_i,
    input logic       fetch_i,
    input logic       wb_cyc_o,
    input logic       wb_stb_o,
    input logic       wb_we_o,
    input logic [3:0] wb_sel_o,
    input logic       wb_ack_i,
    input logic       valid_o
);
    // R3: no strobe in the cycle after a strobed acknowledge
    a_r3_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i) |=> !wb_stb_o);

    // R3 / R2: a held request is strobed again after a quiet cycle
    a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_stb_o && req_i) |=> (req_i -> wb_stb_o));

    // R4: valid only during a strobed cycle
    a_r4_valid_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (wb_cyc_o && wb_ack_i));

    // R11: an acknowledged data access keeps the cycle up
    a_r11_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i && !fetch_i) |=> wb_cyc_o);

    // R11: the cycle is released after an acknowledged fetch
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && wb_ack_i && fetch_i) |=> (!req_i -> !wb_cyc_o));

    // R2: the strobe never appears outside a cycle
    a_r2_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o |-> wb_cyc_o);

    // R5: a byte access enables exactly one lane
    a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !fetch_i && size_i == 2'd1) |-> ($countones(wb_sel_o) == 1));

    // R6: a halfword access enables an aligned lane pair
    a_r6_lane_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !fetch_i && size_i == 2'd2) |-> (wb_sel_o == 4'h3 || wb_sel_o == 4'hC));

    // R8: a fetch is a full-word read
    a_r8_fetch_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && fetch_i) |-> (wb_sel_o == 4'hF && !wb_we_o));

    // R12: write enable only on a strobed store
    a_r12_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we_o |-> (wb_stb_o && write_i));
endmodule

bind lsu_wb_port lsu_wb_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .write_i  (write_i),
    .size_i   (size_i),
    .fetch_i  (fetch_i),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_sel_o (wb_sel_o),
    .wb_ack_i (wb_ack_i),
    .valid_o  (valid_o)
);

// File: tb/test_lsu_wb_port.sv
// Self-checking bench for the load/store lane port.
module test_lsu_wb_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, write_i = 1'b0, sext_i = 1'b0, fetch_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [31:0] addr_i = '0, pc_i = 32'h0000_0100, wdata_i = 32'hA1B2_C3D4;
    logic [31:0] wb_dat_i = 32'h8899_F07F;
    logic        wb_ack_i = 1'b0;
    logic        wb_cyc_o, wb_stb_o, wb_we_o, valid_o;
    logic [31:0] wb_adr_o, wb_dat_o, rdata_o;
    logic [3:0]  wb_sel_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsu_wb_port i_lsu_wb_port (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(write_i),
        .size_i(size_i), .sext_i(sext_i), .fetch_i(fetch_i),
        .addr_i(addr_i), .pc_i(pc_i), .wdata_i(wdata_i),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i),
        .rdata_o(rdata_o), .valid_o(valid_o)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic        sx;
        logic        fe;
        logic [31:0] adr;
        logic [3:0]  x_sel;
        logic [31:0] x_dat;
        logic [31:0] x_rd;
        logic [31:0] x_adr;
        logic        x_we;
    } vec_t;

    // Store data A1B2C3D4, bus read data 8899F07F, PC 00000100 throughout.
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_0040, 4'h1, 32'hD4D4_D4D4, 32'h0000_007F, 32'h0000_0040, 1'b1}, // R5 byte lane 0
        '{1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_0043, 4'h8, 32'hD4D4_D4D4, 32'h0000_0088, 32'h0000_0040, 1'b1}, // R5 byte lane 3
        '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0060, 4'h3, 32'hC3D4_C3D4, 32'h0000_F07F, 32'h0000_0060, 1'b1}, // R6 low half
        '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0062, 4'hC, 32'hC3D4_C3D4, 32'h0000_8899, 32'h0000_0060, 1'b1}, // R6 high half
        '{1'b1, 2'd3, 1'b0, 1'b0, 32'h0000_0084, 4'hF, 32'hA1B2_C3D4, 32'h8899_F07F, 32'h0000_0084, 1'b1}, // R7 word
        '{1'b0, 2'd0, 1'b1, 1'b0, 32'h0000_0088, 4'hF, 32'hA1B2_C3D4, 32'h8899_F07F, 32'h0000_0088, 1'b0}, // R7 auto
        '{1'b0, 2'd1, 1'b1, 1'b0, 32'h0000_0010, 4'h1, 32'hD4D4_D4D4, 32'h0000_007F, 32'h0000_0010, 1'b0}, // R10 positive byte
        '{1'b0, 2'd1, 1'b1, 1'b0, 32'h0000_0011, 4'h2, 32'hD4D4_D4D4, 32'hFFFF_FFF0, 32'h0000_0010, 1'b0}, // R10 byte 1
        '{1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_0011, 4'h2, 32'hD4D4_D4D4, 32'h0000_00F0, 32'h0000_0010, 1'b0}, // R9 byte 1
        '{1'b0, 2'd1, 1'b1, 1'b0, 32'h0000_0013, 4'h8, 32'hD4D4_D4D4, 32'hFFFF_FF88, 32'h0000_0010, 1'b0}, // R10 byte 3
        '{1'b0, 2'd2, 1'b1, 1'b0, 32'h0000_0020, 4'h3, 32'hC3D4_C3D4, 32'hFFFF_F07F, 32'h0000_0020, 1'b0}, // R10 low half
        '{1'b0, 2'd2, 1'b1, 1'b0, 32'h0000_0022, 4'hC, 32'hC3D4_C3D4, 32'hFFFF_8899, 32'h0000_0020, 1'b0}, // R10 high half
        '{1'b0, 2'd3, 1'b1, 1'b0, 32'h0000_0024, 4'hF, 32'hA1B2_C3D4, 32'h8899_F07F, 32'h0000_0024, 1'b0}, // R10 word unchanged
        '{1'b1, 2'd1, 1'b1, 1'b1, 32'h0000_0033, 4'hF, 32'hA1B2_C3D4, 32'h8899_F07F, 32'h0000_0100, 1'b0}  // R8 fetch overrides
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to just after the next falling edge.
    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        // R1: reset state with no request
        check("R1 cyc", {31'b0, wb_cyc_o}, 32'd0);
        check("R1 stb", {31'b0, wb_stb_o}, 32'd0);
        check("R1 valid", {31'b0, valid_o}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R1 cyc after reset", {31'b0, wb_cyc_o}, 32'd0);

        // Table walk: request held, no acknowledge, so no gap is triggered.
        for (int i = 0; i < NV; i++) begin
            write_i = TBL[i].wr; size_i = TBL[i].sz; sext_i = TBL[i].sx;
            fetch_i = TBL[i].fe; addr_i = TBL[i].adr; req_i = 1'b1;
            #1;
            check($sformatf("R5-7 sel row %0d", i), {28'b0, wb_sel_o}, {28'b0, TBL[i].x_sel});
            check($sformatf("R5-7 wdat row %0d", i), wb_dat_o, TBL[i].x_dat);
            check($sformatf("R9 R10 rdata row %0d", i), rdata_o, TBL[i].x_rd);
            check($sformatf("R2 adr row %0d", i), wb_adr_o, TBL[i].x_adr);
            check($sformatf("R12 we row %0d", i), {31'b0, wb_we_o}, {31'b0, TBL[i].x_we});
            step();
        end
        req_i = 1'b0; fetch_i = 1'b0;
        step();

        // R3 / R4: acknowledge gap with request held, store completes
        write_i = 1'b1; size_i = 2'd3; addr_i = 32'h0000_0200;
        req_i = 1'b1; wb_ack_i = 1'b1; #1;
        check("R4 valid on write ack", {31'b0, valid_o}, 32'd1);
        check("R12 we on store", {31'b0, wb_we_o}, 32'd1);
        step();
        check("R3 stb gap", {31'b0, wb_stb_o}, 32'd0);
        check("R4 no valid in gap", {31'b0, valid_o}, 32'd0);
        check("R12 no we in gap", {31'b0, wb_we_o}, 32'd0);
        check("R11 cyc held in gap", {31'b0, wb_cyc_o}, 32'd1);
        wb_ack_i = 1'b0;
        step();
        check("R3 stb resumes", {31'b0, wb_stb_o}, 32'd1);

        // R11: block cycle across the idle gap to the fetch
        req_i = 1'b0; write_i = 1'b0;
        step();
        check("R11 cyc held idle", {31'b0, wb_cyc_o}, 32'd1);
        check("R2 stb low idle", {31'b0, wb_stb_o}, 32'd0);
        fetch_i = 1'b1; req_i = 1'b1; wb_ack_i = 1'b1; #1;
        check("R8 fetch valid", {31'b0, valid_o}, 32'd1);
        check("R8 fetch adr", wb_adr_o, 32'h0000_0100);
        step();
        req_i = 1'b0; wb_ack_i = 1'b0; fetch_i = 1'b0; #1;
        check("R11 cyc released", {31'b0, wb_cyc_o}, 32'd0);

        // R11: a lone fetch does not hold the cycle
        step();
        fetch_i = 1'b1; req_i = 1'b1; wb_ack_i = 1'b1;
        step();
        req_i = 1'b0; wb_ack_i = 1'b0; fetch_i = 1'b0;
        step();
        check("R11 no hold after fetch", {31'b0, wb_cyc_o}, 32'd0);

        // R1: reset clears a pending hold
        size_i = 2'd1; addr_i = 32'h0000_0301; req_i = 1'b1; wb_ack_i = 1'b1;
        step();
        req_i = 1'b0; wb_ack_i = 1'b0; rst_n = 1'b0;
        step();
        rst_n = 1'b1; #1;
        check("R1 hold cleared by reset", {31'b0, wb_cyc_o}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule